// File: doc/BRIEF.md
# Time-Multiplexed Clustered FIR Filter

This block is a programmable-coefficient FIR filter built as a shortened systolic array. The hardware clock runs `P` times faster than the sample rate. Each physical processing element therefore does the work of `P` consecutive tap cells, one tap per fast clock cycle. A filter of `N` taps needs only `ceil(N/P)` elements, and each element has a single multiplier. Throughput is still one result per data period. Every multiplier does useful work in every cycle of a data period. The output is bit-exact with a full-size direct convolution.

A sample arrives with a one-cycle strobe, at most once every `P` clocks. That strobe starts a data period. During the period a shared phase counter steps the tap selection in every element. The counter drives the sample-select and coefficient-select multiplexers. Each element keeps `P` local sample registers, and these are chained into the next element to form the delay line. Each element also holds `P` coefficient slots and one accumulator. On the last phase the partial sums of all elements are added and registered. A one-cycle valid pulse marks the new result.

The sequencer is a small state machine with two states:
- `ST_IDLE`: waiting for a sample.
- `ST_MAC`: stepping through the `P` tap phases.

It has four transitions:
- **start**: `ST_IDLE` to `ST_MAC` when a strobe is accepted.
- **advance**: stay in `ST_MAC` and move from phase k to phase k+1.
- **restart**: stay in `ST_MAC` at the last phase with a new strobe, and return to phase 0.
- **finish**: `ST_MAC` to `ST_IDLE` at the last phase when no strobe is present.

Coefficients are written through a simple address/data port. Slot addresses from `N` up to `ceil(N/P)*P-1` are padding. They always hold zero.

Top module: `clustered_fir`

## Requirements
- R1: After reset, `y_data` is 0, `y_stb` is 0, and all coefficient slots and sample registers are 0. A sample filtered before any coefficient write therefore yields 0.
- R2: For a strobe accepted at clock edge E, `y_stb` is high for exactly the one cycle that follows edge E+P (the P-th rising edge after E), and is low in the cycles before it.
- R3: The result issued for the k-th accepted sample equals the signed sum over i=0..N-1 of b[i]*x[k-i], exact at full width `DW+CW+clog2(N)`. Samples from before the first accepted one count as 0.
- R4: A strobe is accepted while the sequencer is idle, or in the last phase of a data period, so samples may arrive back to back every P cycles with one result per sample.
- R5: A strobe raised during phases 0..P-2 of a data period is ignored. It shifts no sample into the delay line and produces no additional `y_stb` pulse.
- R6: A write with `cf_we`=1 and `cf_addr`=a, where a<N, sets coefficient b[a] to `cf_data` (signed, two's complement) from the next cycle on. Writes to addresses a>=N are ignored, and those slots keep multiplying by zero.
- R7: `y_data` keeps its value in every cycle in which `y_stb` is low.
- R8: Gaps between samples longer than P cycles are allowed. No `y_stb` pulse occurs without an accepted strobe.
- R9: Full-scale negative samples and coefficients (-2^(DW-1) and -2^(CW-1)) on all taps produce the exact positive sum without overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, P cycles per data period |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_stb | input | 1 | Sample strobe, one cycle per sample |
| smp_data | input | DW | Signed input sample |
| cf_we | input | 1 | Coefficient write enable |
| cf_addr | input | clog2(ceil(N/P)*P) | Coefficient slot address (tap index) |
| cf_data | input | CW | Signed coefficient value |
| y_data | output | DW+CW+clog2(N) | Signed filter output |
| y_stb | output | 1 | One-cycle result valid pulse |

## Verification
The bench uses several input patterns, and each one separates a different kind of fault:
- **Single impulse, distinct coefficients.** The output sequence spells out the coefficients in tap order. This exposes a wrong phase-to-slot mapping or a broken inter-element sample chain.
- **Pseudo-random samples every P cycles.** This exercises the restart transition, where the final multiply and the next sample shift share one edge.
- **Samples with long idle gaps.** This separates the finish path from the restart path.
- **Spurious strobes in mid-period.** These show whether a strobe that should be ignored corrupts the history.
- **Stream after writes to padding addresses.** The history is made long enough that a wrongly stored padding coefficient would change the output.
- **Full-scale negative stream.** This tests sign extension and the accumulator width.

// File: rtl/clfir_pkg.sv
package clfir_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_MAC  = 1'b1
    } clfir_state_e;

    function automatic int clfir_cdiv(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

    function automatic int clfir_bits(input int v);
        return (v <= 2) ? 1 : $clog2(v);
    endfunction

endpackage

// File: rtl/clfir_seq.sv
module clfir_seq
    import clfir_pkg::*;
#(
    parameter int P    = 4,
    parameter int PH_W = clfir_bits(P)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stb,
    output logic            take,
    output logic            mac_en,
    output logic            last,
    output logic [PH_W-1:0] phase
);

    localparam logic [PH_W-1:0] PH_LAST = PH_W'(P - 1);

    clfir_state_e    st_q, st_d;
    logic [PH_W-1:0] ph_q, ph_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
            ph_q <= '0;
        end else begin
            st_q <= st_d;
            ph_q <= ph_d;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        ph_d = ph_q;
        unique case (st_q)
            ST_IDLE: begin
                if (stb) begin
                    st_d = ST_MAC;          // start
                    ph_d = '0;
                end
            end
            ST_MAC: begin
                if (ph_q == PH_LAST) begin
                    ph_d = '0;
                    st_d = stb ? ST_MAC : ST_IDLE; // restart / finish
                end else begin
                    ph_d = ph_q + PH_W'(1); // advance
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        mac_en = (st_q == ST_MAC);
        last   = (st_q == ST_MAC) && (ph_q == PH_LAST);
        take   = stb && ((st_q == ST_IDLE) || last);
        phase  = ph_q;
    end

    p_phase_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ph_q <= PH_LAST);

    p_early_strobe_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_MAC && ph_q != PH_LAST && stb)
        |=> (st_q == ST_MAC && ph_q == $past(ph_q) + PH_W'(1)));

    p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (last && stb) |=> (st_q == ST_MAC && ph_q == '0));

endmodule

// File: rtl/clfir_pe.sv
module clfir_pe
    import clfir_pkg::*;
#(
    parameter int P    = 4,
    parameter int N    = 10,
    parameter int BASE = 0,
    parameter int DW   = 16,
    parameter int CW   = 16,
    parameter int AW   = 36,
    parameter int AD_W = 4,
    parameter int PH_W = clfir_bits(P)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   take,
    input  logic                   mac_en,
    input  logic                   last,
    input  logic [PH_W-1:0]        phase,
    input  logic signed [DW-1:0]   x_in,
    output logic signed [DW-1:0]   x_out,
    input  logic                   cf_we,
    input  logic [AD_W-1:0]        cf_addr,
    input  logic signed [CW-1:0]   cf_data,
    output logic signed [AW-1:0]   part
);

    localparam int PW = DW + CW;

    logic signed [DW-1:0] line_q [P];
    logic signed [CW-1:0] cf     [P];
    logic signed [AW-1:0] acc_q;
    logic signed [DW-1:0] sel_x;
    logic signed [CW-1:0] sel_c;
    logic signed [PW-1:0] prod;
    logic signed [AW-1:0] prod_x;

    // local stretch of the sample delay line
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < P; k++) line_q[k] <= '0;
        end else if (take) begin
            line_q[0] <= x_in;
            for (int k = 1; k < P; k++) line_q[k] <= line_q[k-1];
        end
    end

    assign x_out = line_q[P-1];

    // coefficient slots; padding slots are tied to zero
    for (genvar k = 0; k < P; k++) begin : g_slot
        if (BASE + k < N) begin : g_live
            logic signed [CW-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    q <= '0;
                else if (cf_we && cf_addr == AD_W'(BASE + k))
                    q <= cf_data;
            end
            assign cf[k] = q;

            p_cf_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (cf_we && cf_addr == AD_W'(BASE + k)) |=> (q == $past(cf_data)));
        end else begin : g_pad
            assign cf[k] = '0;
        end
    end

    // per-phase tap selection and multiply-accumulate
    always_comb begin
        sel_x  = line_q[phase];
        sel_c  = cf[phase];
        prod   = sel_x * sel_c;
        prod_x = {{(AW - PW){prod[PW-1]}}, prod};
        part   = acc_q + prod_x;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            acc_q <= '0;
        else if (mac_en)
            acc_q <= last ? '0 : part;
    end

    p_sample_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (line_q[0] == $past(x_in)));

    p_hist_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(line_q[0]));

endmodule

// File: rtl/clustered_fir.sv
module clustered_fir
    import clfir_pkg::*;
#(
    parameter int N    = 10,
    parameter int P    = 4,
    parameter int DW   = 16,
    parameter int CW   = 16,
    parameter int M    = clfir_cdiv(N, P),
    parameter int AW   = DW + CW + clfir_bits(N),
    parameter int AD_W = clfir_bits(M * P)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_stb,
    input  logic signed [DW-1:0] smp_data,
    input  logic                 cf_we,
    input  logic [AD_W-1:0]      cf_addr,
    input  logic signed [CW-1:0] cf_data,
    output logic signed [AW-1:0] y_data,
    output logic                 y_stb
);

    localparam int PH_W = clfir_bits(P);

    logic            take, mac_en, last;
    logic [PH_W-1:0] phase;

    logic signed [DW-1:0] xc   [M+1];
    logic signed [AW-1:0] part [M];
    logic signed [AW-1:0] total;

    clfir_seq #(.P(P), .PH_W(PH_W)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .stb    (smp_stb),
        .take   (take),
        .mac_en (mac_en),
        .last   (last),
        .phase  (phase)
    );

    assign xc[0] = smp_data;

    for (genvar j = 0; j < M; j++) begin : g_pe
        clfir_pe #(
            .P(P), .N(N), .BASE(j * P), .DW(DW), .CW(CW),
            .AW(AW), .AD_W(AD_W), .PH_W(PH_W)
        ) u_pe (
            .clk     (clk),
            .rst_n   (rst_n),
            .take    (take),
            .mac_en  (mac_en),
            .last    (last),
            .phase   (phase),
            .x_in    (xc[j]),
            .x_out   (xc[j+1]),
            .cf_we   (cf_we),
            .cf_addr (cf_addr),
            .cf_data (cf_data),
            .part    (part[j])
        );
    end

    always_comb begin
        total = '0;
        for (int j = 0; j < M; j++) total = total + part[j];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            y_data <= '0;
            y_stb  <= 1'b0;
        end else begin
            y_stb <= last;
            if (last) y_data <= total;
        end
    end

    p_result_after_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> y_stb);

    p_no_stray_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mac_en |=> !y_stb);

    p_output_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !y_stb |-> $stable(y_data));

endmodule

// File: tb/clustered_fir_tb.sv
module clustered_fir_tb_top;

    localparam int N    = 10;
    localparam int P    = 4;
    localparam int DW   = 16;
    localparam int CW   = 16;
    localparam int M    = (N + P - 1) / P;
    localparam int AW   = DW + CW + $clog2(N);
    localparam int AD_W = $clog2(M * P);

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 smp_stb = 1'b0;
    logic signed [DW-1:0] smp_data = '0;
    logic                 cf_we = 1'b0;
    logic [AD_W-1:0]      cf_addr = '0;
    logic signed [CW-1:0] cf_data = '0;
    logic signed [AW-1:0] y_data;
    logic                 y_stb;

    int     n_chk = 0;
    int     n_fail = 0;
    longint bq   [N];
    longint hist [N];
    longint last_exp = 0;

    always #5 clk = ~clk;

    clustered_fir #(.N(N), .P(P), .DW(DW), .CW(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_data(smp_data),
        .cf_we(cf_we), .cf_addr(cf_addr), .cf_data(cf_data),
        .y_data(y_data), .y_stb(y_stb)
    );

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint conv();
        longint s = 0;
        for (int i = 0; i < N; i++) s += bq[i] * hist[i];
        return s;
    endfunction

    task automatic write_cf(input int a, input int v);
        @(negedge clk);
        cf_we = 1'b1; cf_addr = AD_W'(a); cf_data = CW'(v);
        if (a < N) bq[a] = longint'(v);
        @(negedge clk);
        cf_we = 1'b0;
    endtask

    // mode 0 pseudo-random, 1 impulse, 2 full-scale negative
    task automatic run_stream(input string req, input int count, input int spacing,
                              input bit spurious, input int mode, input int seed);
        longint expq[$];
        int got = 0;
        int total_cyc = count * spacing + P + 3;
        for (int cyc = 0; cyc < total_cyc; cyc++) begin
            @(negedge clk);
            if (y_stb) begin
                got++;
                if (expq.size() > 0) begin
                    last_exp = expq.pop_front();
                    check(longint'(y_data) == last_exp, req, longint'(y_data), last_exp);
                end else begin
                    check(1'b0, "R8 stray pulse", 1, 0);
                end
            end
            smp_stb = 1'b0;
            if ((cyc % spacing == 0) && (cyc / spacing < count)) begin
                int k = cyc / spacing;
                int v;
                if (mode == 1)      v = (k == 0) ? 1 : 0;
                else if (mode == 2) v = -(1 << (DW - 1));
                else                v = ((k * 40503 + seed * 977) % 65536) - 32768;
                smp_stb = 1'b1;
                smp_data = DW'(v);
                for (int i = N - 1; i > 0; i--) hist[i] = hist[i-1];
                hist[0] = longint'(v);
                expq.push_back(conv());
            end else if (spurious && P >= 2 && (cyc % spacing == 1) && (cyc / spacing < count)) begin
                smp_stb = 1'b1;
                smp_data = DW'(12345);
            end
        end
        @(negedge clk);
        smp_stb = 1'b0;
        check(got == count, {req, " pulse count"}, got, count);
    endtask

    task automatic t_reset_r1();
        @(negedge clk);
        check(y_data == '0, "R1 reset y_data", longint'(y_data), 0);
        check(y_stb == 1'b0, "R1 reset y_stb", y_stb, 0);
        run_stream("R1 zero coefficients", 2, P, 1'b0, 0, 3);
    endtask

    task automatic t_latency_r2();
        int seen = 0;
        @(negedge clk);
        smp_stb = 1'b1; smp_data = DW'(5);
        for (int i = N - 1; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = 5;
        @(negedge clk);   // edge E passed
        smp_stb = 1'b0;
        for (int c = 1; c < P; c++) begin
            @(negedge clk);
            if (y_stb) seen++;
        end
        check(seen == 0, "R2 early pulse", seen, 0);
        @(negedge clk);   // edge E+P passed
        check(y_stb == 1'b1, "R2 pulse timing", y_stb, 1);
        check(longint'(y_data) == conv(), "R2 R3 value", longint'(y_data), conv());
        last_exp = conv();
        @(negedge clk);
        check(y_stb == 1'b0, "R2 single cycle", y_stb, 0);
    endtask

    task automatic t_impulse_r3();
        for (int i = 0; i < N; i++) write_cf(i, (i + 1) * ((i % 2) ? -3 : 7));
        run_stream("R3 impulse", N + 3, P, 1'b0, 1, 0);
    endtask

    task automatic t_back_to_back_r4();
        run_stream("R4 back-to-back", 24, P, 1'b0, 0, 11);
    endtask

    task automatic t_spurious_r5();
        run_stream("R5 mid-period strobe ignored", 16, P, 1'b1, 0, 29);
    endtask

    task automatic t_unused_slots_r6();
        write_cf(N, 30000);
        if (N + 1 < M * P) write_cf(N + 1, -25000);
        write_cf(3, -1234);
        run_stream("R6 padding writes ignored", N + 6, P, 1'b0, 0, 47);
    endtask

    task automatic t_hold_r7();
        int moved = 0;
        for (int c = 0; c < 12; c++) begin
            @(negedge clk);
            if (y_stb || longint'(y_data) != last_exp) moved++;
        end
        check(moved == 0, "R7 output hold", moved, 0);
    endtask

    task automatic t_gaps_r8();
        run_stream("R8 idle gaps", 10, 2 * P + 3, 1'b0, 0, 5);
    endtask

    task automatic t_full_scale_r9();
        for (int i = 0; i < N; i++) write_cf(i, -(1 << (CW - 1)));
        run_stream("R9 full-scale", N + 2, P, 1'b0, 2, 0);
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin bq[i] = 0; hist[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_r1();
        t_latency_r2();
        t_impulse_r3();
        t_back_to_back_r4();
        t_hold_r7();
        t_spurious_r5();
        t_unused_slots_r6();
        t_gaps_r8();
        t_full_scale_r9();
        t_hold_r7();
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

endmodule